// File: doc/BRIEF.md
# Lazy Transactional Commit Arbiter

This block lets several hardware transactions, one per core, run optimistically and then commit one at a time. While a transaction runs, its read and write line addresses are recorded only inside this block, in two Bloom-filter signatures (read set and write set). The write addresses also go into a short exact list. No conflict check happens during execution. When a core wants to commit, it raises its commit request. The arbiter grants permission to exactly one transaction. It then replays that transaction's write list, one address per cycle, against the signatures of every other live transaction. A hit aborts the other transaction with a one-cycle pulse. A false positive of the filter counts as a real conflict. A single token, steered by an external owner input, marks one transaction that may never be aborted and that always wins arbitration.

Two states drive the block. In `ST_IDLE` it picks a winner among the live requesters: the token holder first, otherwise round robin starting after the previous winner. The transition *grant* moves it to `ST_BCAST`. In `ST_BCAST` the grant is held while one write-list entry is checked per cycle. The transition *retire* happens after the last entry, or after one cycle if the list is empty. It returns the block to `ST_IDLE` and clears the committer's tracking state. A victim that is aborted, or a committer that has retired, is dead. Its reads, writes and commit requests are then ignored until it raises begin again.

Top module: `lazy_commit_arbiter`

## Requirements
- R1: While reset is held and right after it, no commit grant and no abort is driven.
- R2: At most one grant is high at any time. A grant goes only to a transaction that is live (begun and neither committed nor aborted since) and is requesting commit.
- R3: Among live requesters without the token, the grant goes to the first index at or after one past the previous winner, wrapping around. After reset the search starts at index 0.
- R4: When the token is valid and its holder (token_id_i) is a live requester, the holder is granted ahead of all others.
- R5: A grant is one cycle in ST_IDLE after the request is seen. It then stays high for as many cycles as the committer's write list has entries, or for one cycle if the list is empty.
- R6: Let entry k be checked in grant cycle k (counting from 0). A live transaction other than the committer is aborted in cycle k+1 if its read signature or its write signature has both hash bits of that entry set. Hash 1 is the XOR of the 8-bit chunks of the 24-bit address, with chunk 0 as bits 7:0. Hash 2 is the XOR of chunk c rotated left by c bits.
- R7: A signature false positive aborts the victim. Example: reads of 0x000001 and 0x000002 make a broadcast of 0x000100 hit.
- R8: The transaction that holds the valid token is never aborted.
- R9: An abort is a single-cycle pulse. The victim's commit request is then ignored, and its old read and write sets no longer cause conflicts after it begins again.
- R10: Transactions whose signatures miss every broadcast address are not aborted. Reads and writes alone never cause an abort.
- R11: After its grant retires, a committer's request is ignored until it begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_begin_i | input | N | Start or restart of a transaction, per core |
| rd_vld_i | input | N | Transactional read valid, per core |
| rd_addr_i | input | N x AW | Read line address, per core |
| wr_vld_i | input | N | Transactional write valid, per core |
| wr_addr_i | input | N x AW | Write line address, per core |
| commit_req_i | input | N | Commit request, per core |
| token_vld_i | input | 1 | The priority token is owned |
| token_id_i | input | IDW | Index of the token owner |
| commit_gnt_o | output | N | Commit permission, held during the broadcast |
| abort_o | output | N | One-cycle abort pulse to the victim |

## Verification
The hardest case to reach is an abort caused only by the union of two unrelated reads, a Bloom-filter false positive. The stimulus gets there by picking two read addresses whose hash bits together cover both bits of a third, distinct write address. A second hard case is an abort on a middle entry of a multi-entry broadcast, followed by later entries that must leave the dead victim alone. This needs a three-entry write list with only the middle address shared. The victim then restarts on a fresh address to show that its old sets were dropped. Token immunity and round-robin ordering are reached by raising several requests in the same cycle after a known history of winners.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BCAST = 1'b1
    } ctm_state_e;
endpackage

// File: rtl/ctm_hash.sv
module ctm_hash #(
    parameter int AW = 24,
    parameter int SW = 8
) (
    input  logic [AW-1:0] addr_i,
    output logic [SW-1:0] h1_o,
    output logic [SW-1:0] h2_o
);
    localparam int NCH = (AW + SW - 1) / SW;

    logic [NCH*SW-1:0] pad;
    logic [SW-1:0]     chunk;

    always_comb begin
        pad = '0;
        pad[AW-1:0] = addr_i;
        h1_o = '0;
        h2_o = '0;
        chunk = '0;
        for (int k = 0; k < NCH; k++) begin
            chunk = pad[k*SW +: SW];
            h1_o = h1_o ^ chunk;
            if ((k % SW) == 0)
                h2_o = h2_o ^ chunk;
            else
                h2_o = h2_o ^ ((chunk << (k % SW)) | (chunk >> (SW - (k % SW))));
        end
    end
endmodule

// File: rtl/ctm_txn_track.sv
module ctm_txn_track #(
    parameter int AW       = 24,
    parameter int SIG_BITS = 256,
    parameter int WS_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        begin_i,
    input  logic                        rd_vld_i,
    input  logic [AW-1:0]               rd_addr_i,
    input  logic                        wr_vld_i,
    input  logic [AW-1:0]               wr_addr_i,
    input  logic                        clr_i,
    input  logic                        probe_vld_i,
    input  logic [$clog2(SIG_BITS)-1:0] probe_h1_i,
    input  logic [$clog2(SIG_BITS)-1:0] probe_h2_i,
    input  logic [((WS_DEPTH>1)?$clog2(WS_DEPTH):1)-1:0] rd_idx_i,
    output logic                        active_o,
    output logic                        hit_o,
    output logic [$clog2(WS_DEPTH+1)-1:0] cnt_o,
    output logic [AW-1:0]               entry_o
);
    localparam int SW = $clog2(SIG_BITS);
    localparam int CW = $clog2(WS_DEPTH + 1);
    localparam int IW = (WS_DEPTH > 1) ? $clog2(WS_DEPTH) : 1;

    logic [SIG_BITS-1:0]          rsig, wsig;
    logic [WS_DEPTH-1:0][AW-1:0]  wlist;
    logic [CW-1:0]                cnt;
    logic                         active;
    logic [SW-1:0]                rh1, rh2, wh1, wh2;

    ctm_hash #(.AW(AW), .SW(SW)) u_rd_hash (.addr_i(rd_addr_i), .h1_o(rh1), .h2_o(rh2));
    ctm_hash #(.AW(AW), .SW(SW)) u_wr_hash (.addr_i(wr_addr_i), .h1_o(wh1), .h2_o(wh2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            rsig   <= '0;
            wsig   <= '0;
            cnt    <= '0;
            wlist  <= '0;
        end else if (begin_i) begin
            active <= 1'b1;
            rsig   <= '0;
            wsig   <= '0;
            cnt    <= '0;
        end else if (clr_i) begin
            active <= 1'b0;
            rsig   <= '0;
            wsig   <= '0;
            cnt    <= '0;
        end else if (active) begin
            if (rd_vld_i) begin
                rsig[rh1] <= 1'b1;
                rsig[rh2] <= 1'b1;
            end
            if (wr_vld_i) begin
                wsig[wh1] <= 1'b1;
                wsig[wh2] <= 1'b1;
                if (cnt < CW'(WS_DEPTH)) begin
                    wlist[cnt[IW-1:0]] <= wr_addr_i;
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign active_o = active;
    assign cnt_o    = cnt;
    assign entry_o  = wlist[rd_idx_i];
    assign hit_o    = probe_vld_i && active &&
                      ((rsig[probe_h1_i] && rsig[probe_h2_i]) ||
                       (wsig[probe_h1_i] && wsig[probe_h2_i]));

    // a cleared transaction holds no write entries
    assert_cleared_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !begin_i) |=> (cnt_o == '0 && !active_o));
endmodule

// File: rtl/ctm_rr_pick.sv
module ctm_rr_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]                     req_i,
    input  logic [((N>1)?$clog2(N):1)-1:0]   ptr_i,
    input  logic                             tok_vld_i,
    input  logic [((N>1)?$clog2(N):1)-1:0]   tok_id_i,
    output logic                             any_o,
    output logic [((N>1)?$clog2(N):1)-1:0]   win_o
);
    localparam int IDW = (N > 1) ? $clog2(N) : 1;

    logic found;
    int   cand;

    always_comb begin
        found = 1'b0;
        cand  = 0;
        win_o = '0;
        if (tok_vld_i && (int'(tok_id_i) < N) && req_i[tok_id_i]) begin
            found = 1'b1;
            win_o = tok_id_i;
        end else begin
            for (int k = 0; k < N; k++) begin
                cand = (int'(ptr_i) + k) % N;
                if (!found && req_i[cand]) begin
                    found = 1'b1;
                    win_o = IDW'(cand);
                end
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/lazy_commit_arbiter.sv
module lazy_commit_arbiter
    import ctm_pkg::*;
#(
    parameter int N        = 4,
    parameter int AW       = 24,
    parameter int SIG_BITS = 256,
    parameter int WS_DEPTH = 4,
    localparam int IDW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         txn_begin_i,
    input  logic [N-1:0]         rd_vld_i,
    input  logic [N-1:0][AW-1:0] rd_addr_i,
    input  logic [N-1:0]         wr_vld_i,
    input  logic [N-1:0][AW-1:0] wr_addr_i,
    input  logic [N-1:0]         commit_req_i,
    input  logic                 token_vld_i,
    input  logic [IDW-1:0]       token_id_i,
    output logic [N-1:0]         commit_gnt_o,
    output logic [N-1:0]         abort_o
);
    localparam int SW = $clog2(SIG_BITS);
    localparam int CW = $clog2(WS_DEPTH + 1);
    localparam int IW = (WS_DEPTH > 1) ? $clog2(WS_DEPTH) : 1;

    ctm_state_e state, state_nx;
    logic [IDW-1:0] owner, owner_nx, ptr, ptr_nx;
    logic [CW-1:0]  idx, idx_nx;

    logic [N-1:0]           active_all, hit_all, clr_vec, abort_d, done_vec;
    logic [N-1:0]           own_mask, tok_mask, req_elig;
    logic [N-1:0][CW-1:0]   cnt_all;
    logic [N-1:0][AW-1:0]   entry_all;
    logic [N-1:0]           abort_q;
    logic                   pick_any, probe_vld, last;
    logic [IDW-1:0]         pick_win;
    logic [CW-1:0]          own_cnt;
    logic [AW-1:0]          probe_addr;
    logic [SW-1:0]          ph1, ph2;

    assign own_cnt    = cnt_all[owner];
    assign probe_addr = entry_all[owner];
    assign probe_vld  = (state == ST_BCAST) && (own_cnt != '0);
    assign last       = (own_cnt == '0) || ((idx + CW'(1)) == own_cnt);
    assign req_elig   = commit_req_i & active_all;

    always_comb begin
        own_mask = '0;
        tok_mask = '0;
        own_mask[owner] = 1'b1;
        if (token_vld_i) tok_mask[token_id_i] = 1'b1;
    end

    ctm_hash #(.AW(AW), .SW(SW)) u_probe_hash (.addr_i(probe_addr), .h1_o(ph1), .h2_o(ph2));

    ctm_rr_pick #(.N(N)) u_pick (
        .req_i(req_elig), .ptr_i(ptr), .tok_vld_i(token_vld_i),
        .tok_id_i(token_id_i), .any_o(pick_any), .win_o(pick_win)
    );

    for (genvar g = 0; g < N; g++) begin : g_trk
        ctm_txn_track #(.AW(AW), .SIG_BITS(SIG_BITS), .WS_DEPTH(WS_DEPTH)) u_trk (
            .clk(clk), .rst_n(rst_n),
            .begin_i(txn_begin_i[g]),
            .rd_vld_i(rd_vld_i[g]), .rd_addr_i(rd_addr_i[g]),
            .wr_vld_i(wr_vld_i[g]), .wr_addr_i(wr_addr_i[g]),
            .clr_i(clr_vec[g]),
            .probe_vld_i(probe_vld), .probe_h1_i(ph1), .probe_h2_i(ph2),
            .rd_idx_i(idx[IW-1:0]),
            .active_o(active_all[g]), .hit_o(hit_all[g]),
            .cnt_o(cnt_all[g]), .entry_o(entry_all[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            owner   <= '0;
            ptr     <= '0;
            idx     <= '0;
            abort_q <= '0;
        end else begin
            state   <= state_nx;
            owner   <= owner_nx;
            ptr     <= ptr_nx;
            idx     <= idx_nx;
            abort_q <= abort_d;
        end
    end

    // next state and transition decode
    always_comb begin
        state_nx = state;
        owner_nx = owner;
        ptr_nx   = ptr;
        idx_nx   = idx;
        done_vec = '0;
        unique case (state)
            ST_IDLE: begin
                if (pick_any) begin
                    state_nx = ST_BCAST;
                    owner_nx = pick_win;
                    idx_nx   = '0;
                    ptr_nx   = (int'(pick_win) == N - 1) ? '0 : pick_win + IDW'(1);
                end
            end
            ST_BCAST: begin
                if (last) begin
                    state_nx = ST_IDLE;
                    done_vec = own_mask;
                end else begin
                    idx_nx = idx + CW'(1);
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        abort_d = hit_all & ~own_mask & ~tok_mask;
        clr_vec = abort_d | done_vec;
    end

    // outputs
    always_comb begin
        commit_gnt_o = (state == ST_BCAST) ? own_mask : '0;
        abort_o      = abort_q;
    end

    assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(commit_gnt_o));

    assert_gnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BCAST && !last) |=> (commit_gnt_o == $past(commit_gnt_o)));

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_gnt_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(commit_gnt_o[g]) |-> $past(commit_req_i[g]));
        assert_abort_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
            abort_o[g] |=> !abort_o[g]);
        assert_token_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
            abort_o[g] |-> !($past(token_vld_i) && int'($past(token_id_i)) == g));
        assert_committer_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
            abort_o[g] |-> !$past(commit_gnt_o[g]));
    end
endmodule

// File: tb/tb_lazy_commit_arbiter.sv
module tb_lazy_commit_arbiter;
    localparam int N = 4;
    localparam int AW = 24;
    localparam int IDW = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n;
    logic [N-1:0]         txn_begin, rd_vld, wr_vld, commit_req;
    logic [N-1:0][AW-1:0] rd_addr, wr_addr;
    logic                 token_vld;
    logic [IDW-1:0]       token_id;
    logic [N-1:0]         commit_gnt, abort_v;

    lazy_commit_arbiter #(.N(N), .AW(AW), .SIG_BITS(256), .WS_DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .txn_begin_i(txn_begin),
        .rd_vld_i(rd_vld), .rd_addr_i(rd_addr), .wr_vld_i(wr_vld), .wr_addr_i(wr_addr),
        .commit_req_i(commit_req), .token_vld_i(token_vld), .token_id_i(token_id),
        .commit_gnt_o(commit_gnt), .abort_o(abort_v)
    );

    typedef struct { int kind; int core; int len; string req; } ev_t;  // kind 0 commit, 1 abort
    ev_t exp_q[$];
    int errors = 0;
    int checks = 0;
    int glen [N];
    logic [N-1:0] gprev;

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push_ev(input int kind, input int core, input int len, input string req);
        ev_t e;
        e.kind = kind; e.core = core; e.len = len; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic got(input int kind, input int core, input int len);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected event kind=%0d core=%0d len=%0d actual=1 expected=0", kind, core, len);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.core != core || (kind == 0 && e.len != len)) begin
                errors++;
                $display("FAIL %s event actual kind=%0d core=%0d len=%0d expected kind=%0d core=%0d len=%0d",
                         e.req, kind, core, len, e.kind, e.core, e.len);
            end
        end
    endtask

    // monitor: aborts first, then grant completions
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++)
                if (abort_v[i]) got(1, i, 0);
            for (int i = 0; i < N; i++) begin
                if (commit_gnt[i]) glen[i]++;
                else if (gprev[i]) begin
                    got(0, i, glen[i]);
                    glen[i] = 0;
                end
            end
            gprev = commit_gnt;
        end else begin
            gprev = '0;
            for (int i = 0; i < N; i++) glen[i] = 0;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic tbegin(input int i);
        txn_begin[i] = 1'b1; step(); txn_begin[i] = 1'b0;
    endtask

    task automatic trd(input int i, input logic [AW-1:0] a);
        rd_vld[i] = 1'b1; rd_addr[i] = a; step(); rd_vld[i] = 1'b0;
    endtask

    task automatic twr(input int i, input logic [AW-1:0] a);
        wr_vld[i] = 1'b1; wr_addr[i] = a; step(); wr_vld[i] = 1'b0;
    endtask

    task automatic treq(input logic [N-1:0] m, input int cyc);
        commit_req = commit_req | m;
        repeat (cyc) step();
        commit_req = commit_req & ~m;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; txn_begin = '0; rd_vld = '0; wr_vld = '0; commit_req = '0;
        rd_addr = '0; wr_addr = '0; token_vld = 1'b0; token_id = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(commit_gnt == '0, "R1", "grant in reset", int'(commit_gnt), 0);
        check(abort_v == '0, "R1", "abort in reset", int'(abort_v), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(commit_gnt == '0 && abort_v == '0, "R1", "outputs after reset",
              int'({commit_gnt, abort_v}), 0);
        step();

        // S2: read-write conflict on entry 0 of two (R6, R5, R10)
        tbegin(0); tbegin(1);
        trd(1, 24'h000010);
        twr(0, 24'h000010); twr(0, 24'h000020);
        push_ev(1, 1, 0, "R6"); push_ev(0, 0, 2, "R5");
        treq(4'b0001, 8);
        // R9: aborted core's request is ignored
        commit_req[1] = 1'b1;
        repeat (3) step();
        @(negedge clk);
        check(commit_gnt == '0, "R9", "grant to aborted core", int'(commit_gnt), 0);
        step(); commit_req[1] = 1'b0; step();

        // S3: write-write conflict, bystander survives, empty commit (R6, R10, R5)
        tbegin(0); tbegin(1); tbegin(2);
        twr(1, 24'h000030);
        trd(2, 24'h000555);
        twr(0, 24'h000030);
        push_ev(1, 1, 0, "R6"); push_ev(0, 0, 1, "R5");
        treq(4'b0001, 6);
        push_ev(0, 2, 1, "R10");
        treq(4'b0100, 6);

        // S4: false positive from two reads (R7)
        tbegin(0); tbegin(1);
        trd(1, 24'h000001); trd(1, 24'h000002);
        twr(0, 24'h000100);
        push_ev(1, 1, 0, "R7"); push_ev(0, 0, 1, "R5");
        treq(4'b0001, 6);

        // S5: round robin, previous winner 0 (R3)
        tbegin(0); tbegin(1); tbegin(2);
        push_ev(0, 1, 1, "R3"); push_ev(0, 2, 1, "R3"); push_ev(0, 0, 1, "R3");
        treq(4'b0111, 12);

        // S6a: token priority over round robin (R4)
        token_vld = 1'b1; token_id = 2'd0;
        tbegin(0); tbegin(2);
        push_ev(0, 0, 1, "R4"); push_ev(0, 2, 1, "R4");
        treq(4'b0101, 10);

        // S6b: token holder is not aborted (R8)
        token_id = 2'd1;
        tbegin(1); tbegin(3);
        trd(1, 24'h000040);
        twr(3, 24'h000040);
        push_ev(0, 3, 1, "R8");
        treq(4'b1000, 6);
        push_ev(0, 1, 1, "R8");
        treq(4'b0010, 6);
        token_vld = 1'b0;

        // S7: abort on middle entry, then restart drops old sets (R6, R9, R11)
        tbegin(0); tbegin(1);
        trd(1, 24'h000070);
        twr(0, 24'h000060); twr(0, 24'h000070); twr(0, 24'h000080);
        push_ev(1, 1, 0, "R6"); push_ev(0, 0, 3, "R5");
        treq(4'b0001, 10);
        tbegin(1); trd(1, 24'h000090);
        tbegin(2); twr(2, 24'h000070);
        push_ev(0, 2, 1, "R9");
        treq(4'b0100, 6);
        push_ev(0, 1, 1, "R9");
        treq(4'b0010, 6);
        // R11: retired committer requests again without begin
        commit_req[0] = 1'b1;
        repeat (3) step();
        @(negedge clk);
        check(commit_gnt == '0, "R11", "grant to retired core", int'(commit_gnt), 0);
        step(); commit_req[0] = 1'b0;
        repeat (4) step();

        check(exp_q.size() == 0, "R2", "missing expected events", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule